// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Edge Interrupts

This block gives a processor sixteen general-purpose I/O lines behind a small register bus. Every line is set up on its own as an input or an output. Output lines drive the value held in a data-out register. Input lines are resynchronised to the bus clock. After that they can be read back through a pin-enable gate, and each one can raise an interrupt on a rising or a falling transition.

Interrupt events collect in a sticky status register. Software clears that register by writing ones to it. A single interrupt line is high while any status bit is set. The bus carries one request per cycle: an 8-bit offset, a 2-bit access size and 16-bit write data. The response (read data and an error flag) is registered and is valid in the cycle after the request. Only halfword (16-bit) accesses take effect. Every other access size is refused with the error flag.

Top module: `gpio16_edge_port`

## Requirements
- R1: After reset the readback values are: data-out 0xFFFF (offset 0x04), direction 0xFFFF (0x08), edge-select 0xFFFF (0x0C), mask 0xFFFF (0x10), status 0x0000 (0x14) and pin-enable 0xFFFF (0x18). At the same point pin_oe is 0, pin_out is 0 and irq is low.
- R2: A direction bit of 0 makes its line an output and a bit of 1 makes it an input. pin_oe equals the inverted direction register, and pin_out carries the data-out bit only on output lines (0 elsewhere). Both follow a direction or data-out write from the first cycle after that write.
- R3: A read of offset 0x00 returns the synchronised pin levels ANDed with pin-enable. A pin change reaches this readback only after two clock edges. Writes to 0x00 have no effect.
- R4: On an input line whose mask bit is 0 and whose edge-select bit is 1, a rising transition sets that line's status bit.
- R5: On such a line with edge-select 0, a falling transition sets the status bit, and a rising transition does not.
- R6: Transitions on masked lines (mask bit 1) and on output lines never set a status bit.
- R7: A halfword write to offset 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R8: irq is high exactly while at least one status bit is set, and it drops once every set bit has been cleared.
- R9: When an edge event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: The access size is 2'b01 for halfword; 2'b00, 2'b10 and 2'b11 are other sizes. An access of any other size sets rsp_err, returns read data 0 and changes no register.
- R11: Reads of offsets outside the map return 0 without an error, and writes to them change nothing.
- R12: Data-out, direction, edge-select, mask and pin-enable each read back the last value written to them with a halfword access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A bus request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register offset |
| req_size | input | 2 | Access size code; only 2'b01 (16-bit) is accepted |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, registered, valid the cycle after the request |
| rsp_err | output | 1 | Size error flag for the previous request |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output drive values (0 on input lines) |
| pin_oe | output | 16 | Output enable per line |
| irq | output | 1 | Summary interrupt, high while any status bit is set |

## Verification
The bench aims a clearing write at the exact cycle in which a new edge on the same line lands. A design that gave the clear priority would lose that event, and irq would drop with an edge still unserviced. It also checks that a pin change reaches the data-in register only after the synchroniser delay. It drives edges on masked lines, on output lines and in the unselected direction, because a detector that ignores the direction or mask bits would raise spurious interrupts there. Bad-size writes and writes to unmapped or read-only offsets are followed by readbacks, which would expose a design that let such an access corrupt a register.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // register offsets (byte addresses, halfword registers on a 4-byte stride)
  localparam logic [ADDR_W-1:0] OFF_DIN  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DOUT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ESEL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PEN  = 8'h18;

endpackage

// File: rtl/gpio16_in_sync.sv
module gpio16_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio16_edge_detect.sv
module gpio16_edge_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] esel,
  input  logic [W-1:0] mask,
  output logic [W-1:0] evt
);

  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise;
    logic fall;
    logic armed;
    assign rise   = lvl[i] & ~prev_q[i];
    assign fall   = ~lvl[i] & prev_q[i];
    assign armed  = dir[i] & ~mask[i];
    assign evt[i] = armed & (esel[i] ? rise : fall);
  end

endmodule

// File: rtl/gpio16_regfile.sv
module gpio16_regfile
  import gpio16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [W-1:0]      req_wdata,
  input  logic [W-1:0]      in_lvl,
  input  logic [W-1:0]      evt,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      esel_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      stat_q,
  output logic              stat_clr_we,
  output logic [W-1:0]      rsp_rdata,
  output logic              rsp_err
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] pen_q;
  logic [W-1:0] dout_d, dir_d, esel_d, mask_d, stat_d, pen_d;
  logic         dout_we, dir_we, esel_we, mask_we, pen_we;
  logic         size_ok, acc_ok, wr_ok, rd_ok;
  logic [W-1:0] clr_bits;
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_d;
  logic         err_d;

  // decode
  always_comb begin
    size_ok     = (req_size == SZ_HALF);
    acc_ok      = req_valid & size_ok;
    wr_ok       = acc_ok & req_write;
    rd_ok       = acc_ok & ~req_write;
    dout_we     = wr_ok & (req_addr == OFF_DOUT);
    dir_we      = wr_ok & (req_addr == OFF_DIR);
    esel_we     = wr_ok & (req_addr == OFF_ESEL);
    mask_we     = wr_ok & (req_addr == OFF_MASK);
    pen_we      = wr_ok & (req_addr == OFF_PEN);
    stat_clr_we = wr_ok & (req_addr == OFF_STAT);
  end

  // next state
  always_comb begin
    dout_d   = req_wdata;
    dir_d    = req_wdata;
    esel_d   = req_wdata;
    mask_d   = req_wdata;
    pen_d    = req_wdata;
    clr_bits = stat_clr_we ? req_wdata : '0;
    // a fresh event wins over a clear in the same cycle
    stat_d   = (stat_q & ~clr_bits) | evt;
  end

  // read mux
  always_comb begin
    unique case (req_addr)
      OFF_DIN:  rd_mux = in_lvl & pen_q;
      OFF_DOUT: rd_mux = dout_q;
      OFF_DIR:  rd_mux = dir_q;
      OFF_ESEL: rd_mux = esel_q;
      OFF_MASK: rd_mux = mask_q;
      OFF_STAT: rd_mux = stat_q;
      OFF_PEN:  rd_mux = pen_q;
      default:  rd_mux = '0;
    endcase
    rdata_d = rd_ok ? rd_mux : '0;
    err_d   = req_valid & ~size_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= ONES;
    end else if (dout_we) begin
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= ONES;
    end else if (dir_we) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esel_q <= ONES;
    end else if (esel_we) begin
      esel_q <= esel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= ONES;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q <= ONES;
    end else if (pen_we) begin
      pen_q <= pen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (req_valid) begin
      rsp_rdata <= rdata_d;
      rsp_err   <= err_d;
    end
  end

endmodule

// File: rtl/gpio16_edge_port.sv
module gpio16_edge_port
  import gpio16_pkg::*;
#(
  parameter int NLINES      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [NLINES-1:0]   req_wdata,
  output logic [NLINES-1:0]   rsp_rdata,
  output logic                rsp_err,
  input  logic [NLINES-1:0]   pin_in,
  output logic [NLINES-1:0]   pin_out,
  output logic [NLINES-1:0]   pin_oe,
  output logic                irq
);

  localparam int W = NLINES;

  logic [W-1:0] in_lvl;
  logic [W-1:0] evt;
  logic [W-1:0] dout_q, dir_q, esel_q, mask_q, stat_q;
  logic         stat_clr_we;

  gpio16_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_lvl)
  );

  gpio16_edge_detect #(.W(W)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (in_lvl),
    .dir   (dir_q),
    .esel  (esel_q),
    .mask  (mask_q),
    .evt   (evt)
  );

  gpio16_regfile #(.W(W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_wdata   (req_wdata),
    .in_lvl      (in_lvl),
    .evt         (evt),
    .dout_q      (dout_q),
    .dir_q       (dir_q),
    .esel_q      (esel_q),
    .mask_q      (mask_q),
    .stat_q      (stat_q),
    .stat_clr_we (stat_clr_we),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err)
  );

  // direction 0 = output
  assign pin_oe  = ~dir_q;
  assign pin_out = dout_q & ~dir_q;
  assign irq     = |stat_q;

endmodule

// File: rtl/gpio16_edge_port_chk.sv
module gpio16_edge_port_chk
  import gpio16_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [W-1:0]      req_wdata,
  input logic [W-1:0]      rsp_rdata,
  input logic              rsp_err,
  input logic [W-1:0]      pin_oe,
  input logic              irq,
  input logic [W-1:0]      stat_q,
  input logic [W-1:0]      evt,
  input logic              stat_clr_we
);

  // R10: a non-halfword access reports an error and returns zero
  p_bad_size_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SZ_HALF) |=> (rsp_err && rsp_rdata == '0));

  // R2: output enables follow a direction write on the next cycle
  p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == SZ_HALF && req_addr == OFF_DIR)
    |=> (pin_oe == ~$past(req_wdata)));

  // R4: the interrupt only rises after a detected edge
  p_irq_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|evt));

  // R7: status bits fall only after a clearing write
  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(stat_q) & ~stat_q)) |-> $past(stat_clr_we));

  // R9: an event always lands in status, whatever else happens that cycle
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R8: clearing every bit with no new event lowers the interrupt
  p_irq_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_we && req_wdata == {W{1'b1}} && evt == '0) |=> !irq);

endmodule

bind gpio16_edge_port gpio16_edge_port_chk #(.W(NLINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_size    (req_size),
  .req_wdata   (req_wdata),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .pin_oe      (pin_oe),
  .irq         (irq),
  .stat_q      (stat_q),
  .evt         (evt),
  .stat_clr_we (stat_clr_we)
);

// File: tb/sim_gpio16_edge_port.sv
`timescale 1ns/1ps
module sim_gpio16_edge_port;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [1:0]  req_size;
  logic [15:0] req_wdata;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  gpio16_edge_port u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // vector: {is_read, addr[7:0], data[15:0]}; reads compare data
  localparam int NV = 22;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h04, 16'hFFFF},   // R1
    {1'b1, 8'h08, 16'hFFFF},   // R1
    {1'b1, 8'h0C, 16'hFFFF},   // R1
    {1'b1, 8'h10, 16'hFFFF},   // R1
    {1'b1, 8'h14, 16'h0000},   // R1
    {1'b1, 8'h18, 16'hFFFF},   // R1
    {1'b1, 8'h00, 16'h0000},   // R3 pins low
    {1'b0, 8'h04, 16'hA5C3},   // R12
    {1'b1, 8'h04, 16'hA5C3},
    {1'b0, 8'h0C, 16'h0F0F},
    {1'b1, 8'h0C, 16'h0F0F},
    {1'b0, 8'h18, 16'h00FF},
    {1'b1, 8'h18, 16'h00FF},
    {1'b0, 8'h10, 16'h1234},
    {1'b1, 8'h10, 16'h1234},
    {1'b0, 8'h20, 16'hBEEF},   // R11
    {1'b1, 8'h20, 16'h0000},
    {1'b1, 8'h1C, 16'h0000},
    {1'b1, 8'h06, 16'h0000},
    {1'b1, 8'h04, 16'hA5C3},
    {1'b1, 8'h08, 16'hFFFF},
    {1'b1, 8'h14, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start just after a falling edge and end just after one
  task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'b01);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d, input logic [1:0] sz = 2'b01);
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_size = 2'b01;
    req_wdata = 0; pin_in = 0;
    idle(3);
    rst_n = 1;
    idle(2);

    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 pin_out", pin_out, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        bus_read(VEC[i][23:16], rd);
        check($sformatf("vec%0d R1/R11/R12 addr %h", i, VEC[i][23:16]), rd, VEC[i][15:0]);
      end else begin
        bus_write(VEC[i][23:16], VEC[i][15:0]);
      end
    end

    // R2: lines 0-7 outputs
    bus_write(8'h08, 16'hFF00);
    check("R2 oe", pin_oe, 16'h00FF);
    check("R2 out", pin_out, 16'h00C3);
    bus_write(8'h04, 16'h003C);
    check("R2 out after dout write", pin_out, 16'h003C);
    bus_write(8'h08, 16'hFFFF);
    check("R2 out released", pin_out, 16'h0000);

    // R3: synchroniser delay and pin-enable gate
    bus_write(8'h18, 16'hFFFF);
    bus_write(8'h10, 16'hFFFF);
    pin_in = 16'hABCD;
    bus_read(8'h00, rd);
    check("R3 sync delay", rd, 16'h0000);
    idle(3);
    bus_read(8'h00, rd);
    check("R3 readback", rd, 16'hABCD);
    bus_write(8'h18, 16'h00FF);
    bus_read(8'h00, rd);
    check("R3 pin-enable gate", rd, 16'h00CD);
    bus_write(8'h00, 16'h0000);
    bus_read(8'h00, rd);
    check("R3 read-only", rd, 16'h00CD);
    pin_in = 16'h0000;
    idle(4);
    bus_write(8'h18, 16'hFFFF);
    bus_read(8'h14, rd);
    check("R6 masked lines quiet", rd, 16'h0000);

    // R4: rising edge on line 0
    bus_write(8'h0C, 16'hFFFF);
    bus_write(8'h10, 16'hFFFE);
    bus_write(8'h14, 16'hFFFF);
    pin_in = 16'h0001;
    idle(4);
    check("R4 irq", {15'd0, irq}, 16'h0001);
    bus_read(8'h14, rd);
    check("R4 status", rd, 16'h0001);

    // R6: masked line 1, output line 2
    pin_in = 16'h0003;
    bus_write(8'h08, 16'hFFFB);
    bus_write(8'h10, 16'hFFFA);
    pin_in = 16'h0007;
    idle(4);
    bus_read(8'h14, rd);
    check("R6 masked/output lines", rd, 16'h0001);

    // R7 / R8: write-one-to-clear
    bus_write(8'h14, 16'h0000);
    bus_read(8'h14, rd);
    check("R7 zero write keeps", rd, 16'h0001);
    check("R8 irq held", {15'd0, irq}, 16'h0001);
    bus_write(8'h14, 16'h0001);
    bus_read(8'h14, rd);
    check("R7 cleared", rd, 16'h0000);
    check("R8 irq low", {15'd0, irq}, 16'h0000);

    // R5: falling edge on line 3
    bus_write(8'h0C, 16'hFFF7);
    bus_write(8'h10, 16'hFFF2);
    pin_in = 16'h000F;
    idle(4);
    bus_read(8'h14, rd);
    check("R5 rise ignored", rd, 16'h0000);
    pin_in = 16'h0007;
    idle(4);
    bus_read(8'h14, rd);
    check("R5 fall detected", rd, 16'h0008);
    check("R8 irq on fall", {15'd0, irq}, 16'h0001);
    bus_write(8'h14, 16'h0008);
    check("R8 irq after clear", {15'd0, irq}, 16'h0000);

    // R9: event and clear in the same cycle
    pin_in = 16'h0006;
    idle(4);
    pin_in = 16'h0007;
    idle(4);
    bus_read(8'h14, rd);
    check("R4 second rise", rd, 16'h0001);
    pin_in = 16'h0006;
    idle(4);
    bus_write(8'h14, 16'h0001);
    pin_in = 16'h0007;          // drive before edge k
    idle(2);                    // now before edge k+2
    bus_write(8'h14, 16'h0001); // clear lands with the event
    bus_read(8'h14, rd);
    check("R9 event wins", rd, 16'h0001);
    bus_write(8'h14, 16'h0001);
    bus_read(8'h14, rd);
    check("R9 later clear works", rd, 16'h0000);

    // R10: bad access sizes
    bus_write(8'h04, 16'h1111, 2'b00);
    check("R10 write err", {15'd0, rsp_err}, 16'h0001);
    bus_write(8'h04, 16'h2222, 2'b10);
    bus_read(8'h04, rd);
    check("R10 no corruption", rd, 16'h003C);
    check("R10 good access no err", {15'd0, rsp_err}, 16'h0000);
    bus_read(8'h04, rd, 2'b10);
    check("R10 read data zero", rd, 16'h0000);
    check("R10 read err", {15'd0, rsp_err}, 16'h0001);
    bus_read(8'h08, rd, 2'b11);
    check("R10 reserved size", rd, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule